// File: doc/BRIEF.md
# AXI4 Burst Bridge for a Wide Client Buffer

This block connects a simple client request port to an AXI4 memory bus. On the client side it is a slave: it takes one read or one write request at a time, each naming a start address and, for writes, one wide buffer holding the whole burst. On the bus side it is a burst master. It cuts that buffer into data-width beats and moves them as a single incrementing (INCR) burst.

A read request launches one read address phase. It then gathers the returned beats into a wide output buffer, with each beat stored at the slot given by its order in the burst, and pulses a data-valid output once the final beat arrives. A write request launches the address phase and the data phase. These may finish in either order. The block waits for the write response before it takes new work. The client can withdraw a read while its address is still waiting to be accepted. A ready output tells the client when a new request will be taken.

Top module: `axi_burst_bridge`

## Requirements
- R1: After reset, `ready_o` is 1, `rd_valid_o` is 0, `rbuf_o` is all zeros, and `arvalid`, `awvalid`, `wvalid`, `rready` and `bready` are 0.
- R2: `ready_o` is 1 only when the block is idle. A request that arrives while `ready_o` is 0 is ignored and starts no bus activity.
- R3: A read request drives `arvalid` in the next cycle. It carries `araddr` equal to the address latched at acceptance, `arid` = 0, `arburst` = 2'b01, `arlen` = BUF_W/DATA_W − 1 and `arsize` = log2(DATA_W/8).
- R4: While `arvalid` is waiting, a high `cancel_i` returns the block to idle with no data beat and no `rd_valid_o`. If `arready` is high in the same cycle, the handshake wins and the read proceeds.
- R5: While read beats are awaited, `rready` is 1. The k-th accepted beat (counting from 0) lands in `rbuf_o[k*DATA_W +: DATA_W]`.
- R6: The cycle after the beat marked `rlast` is accepted, `rd_valid_o` is 1 for exactly one cycle and `ready_o` is 1.
- R7: A write request drives `awaddr` equal to the latched address, `awid` = 0, `awburst` = 2'b01, and `awlen`/`awsize` as in R3. Beat k carries the latched buffer slice `[k*DATA_W +: DATA_W]`, `wstrb` is all ones, and `wlast` is 1 only on beat BUF_W/DATA_W − 1.
- R8: `awvalid` and `wvalid` each stay high with stable payload until their ready is seen. The address and data phases complete independently and in either order.
- R9: `bready` goes high only after both the address phase and the last data beat have been accepted. A `bvalid` handshake then returns the block to idle.
- R10: If read and write requests arrive in the same idle cycle, the read is taken and no write channel becomes active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_rd_i | input | 1 | Client read request |
| req_wr_i | input | 1 | Client write request |
| cancel_i | input | 1 | Withdraw a read whose address is not yet accepted |
| addr_i | input | ADDR_W | Burst start address |
| wbuf_i | input | BUF_W | Wide write buffer |
| ready_o | output | 1 | Block idle, request will be taken |
| rd_valid_o | output | 1 | One-cycle pulse: rbuf_o holds a complete read |
| rbuf_o | output | BUF_W | Wide read buffer |
| arid | output | ID_W | Read ID (zero) |
| araddr | output | ADDR_W | Read address |
| arlen | output | 8 | Read beats minus one |
| arsize | output | 3 | Read beat size code |
| arburst | output | 2 | Read burst type |
| arvalid | output | 1 | Read address valid |
| arready | input | 1 | Read address ready |
| rdata | input | DATA_W | Read data |
| rlast | input | 1 | Final read beat |
| rvalid | input | 1 | Read data valid |
| rready | output | 1 | Read data ready |
| awid | output | ID_W | Write ID (zero) |
| awaddr | output | ADDR_W | Write address |
| awlen | output | 8 | Write beats minus one |
| awsize | output | 3 | Write beat size code |
| awburst | output | 2 | Write burst type |
| awvalid | output | 1 | Write address valid |
| awready | input | 1 | Write address ready |
| wdata | output | DATA_W | Write data |
| wstrb | output | DATA_W/8 | Write byte enables |
| wlast | output | 1 | Final write beat |
| wvalid | output | 1 | Write data valid |
| wready | input | 1 | Write data ready |
| bvalid | input | 1 | Write response valid |
| bready | output | 1 | Write response ready |

## Verification
Two functions can land in one cycle: the client's cancel and the slave's address acceptance. The bench raises `cancel_i` and `arready` on the same edge and expects the read to go on, so `rready` must be high and `ready_o` low in the next cycle, and all beats must then arrive in the buffer. A second run raises `cancel_i` alone and expects an immediate return to idle with no valid pulse. A third run asserts both requests in the same idle cycle and expects only the read channel to open. On the write side, the address and final-data acceptances are delayed against each other in both directions, and the bench judges that `bready` waits for whichever comes later.

// File: rtl/axi_burst_bridge.sv
module axi_burst_bridge #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int BUF_W  = 128,
  parameter int ID_W   = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_rd_i,
  input  logic                req_wr_i,
  input  logic                cancel_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [BUF_W-1:0]    wbuf_i,
  output logic                ready_o,
  output logic                rd_valid_o,
  output logic [BUF_W-1:0]    rbuf_o,
  output logic [ID_W-1:0]     arid,
  output logic [ADDR_W-1:0]   araddr,
  output logic [7:0]          arlen,
  output logic [2:0]          arsize,
  output logic [1:0]          arburst,
  output logic                arvalid,
  input  logic                arready,
  input  logic [DATA_W-1:0]   rdata,
  input  logic                rlast,
  input  logic                rvalid,
  output logic                rready,
  output logic [ID_W-1:0]     awid,
  output logic [ADDR_W-1:0]   awaddr,
  output logic [7:0]          awlen,
  output logic [2:0]          awsize,
  output logic [1:0]          awburst,
  output logic                awvalid,
  input  logic                awready,
  output logic [DATA_W-1:0]   wdata,
  output logic [DATA_W/8-1:0] wstrb,
  output logic                wlast,
  output logic                wvalid,
  input  logic                wready,
  input  logic                bvalid,
  output logic                bready
);
  localparam int BEATS = BUF_W / DATA_W;
  localparam int CNT_W = (BEATS > 1) ? $clog2(BEATS) : 1;
  localparam int STRB_W = DATA_W / 8;
  localparam logic [7:0] LEN = 8'(BEATS - 1);
  localparam logic [2:0] SIZE = 3'($clog2(STRB_W));

  typedef enum logic [1:0] {S_IDLE, S_RD_ADDR, S_RD_DATA, S_WR} st_t;

  st_t              st;
  logic [CNT_W-1:0] cnt;
  logic [ADDR_W-1:0] addr_q;
  logic [BUF_W-1:0] wbuf_q, rbuf_q;
  logic             aw_done, w_done, rd_valid_q;

  wire beat_last = (cnt == CNT_W'(BEATS - 1));

  assign ready_o    = (st == S_IDLE);
  assign rd_valid_o = rd_valid_q;
  assign rbuf_o     = rbuf_q;

  assign arid    = '0;
  assign araddr  = addr_q;
  assign arlen   = LEN;
  assign arsize  = SIZE;
  assign arburst = 2'b01;
  assign arvalid = (st == S_RD_ADDR);
  assign rready  = (st == S_RD_DATA);

  assign awid    = '0;
  assign awaddr  = addr_q;
  assign awlen   = LEN;
  assign awsize  = SIZE;
  assign awburst = 2'b01;
  assign awvalid = (st == S_WR) && !aw_done;
  assign wvalid  = (st == S_WR) && !w_done;
  assign wdata   = wbuf_q[int'(cnt)*DATA_W +: DATA_W];
  assign wstrb   = '1;
  assign wlast   = beat_last;
  assign bready  = (st == S_WR) && aw_done && w_done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      cnt        <= '0;
      addr_q     <= '0;
      wbuf_q     <= '0;
      rbuf_q     <= '0;
      aw_done    <= 1'b0;
      w_done     <= 1'b0;
      rd_valid_q <= 1'b0;
    end else begin
      rd_valid_q <= 1'b0;
      case (st)
        S_IDLE: begin
          cnt     <= '0;
          aw_done <= 1'b0;
          w_done  <= 1'b0;
          if (req_rd_i) begin
            addr_q <= addr_i;
            st     <= S_RD_ADDR;
          end else if (req_wr_i) begin
            addr_q <= addr_i;
            wbuf_q <= wbuf_i;
            st     <= S_WR;
          end
        end
        S_RD_ADDR: begin
          if (arready)       st <= S_RD_DATA;
          else if (cancel_i) st <= S_IDLE;
        end
        S_RD_DATA: begin
          if (rvalid) begin
            rbuf_q[int'(cnt)*DATA_W +: DATA_W] <= rdata;
            cnt <= cnt + 1'b1;
            if (rlast) begin
              st         <= S_IDLE;
              rd_valid_q <= 1'b1;
            end
          end
        end
        S_WR: begin
          if (awvalid && awready) aw_done <= 1'b1;
          if (wvalid && wready) begin
            if (beat_last) w_done <= 1'b1;
            else           cnt    <= cnt + 1'b1;
          end
          if (bready && bvalid) st <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/axi_burst_bridge_chk.sv
module axi_burst_bridge_chk #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ready_o,
  input logic              rd_valid_o,
  input logic              cancel_i,
  input logic [ADDR_W-1:0] araddr,
  input logic              arvalid,
  input logic              arready,
  input logic              rready,
  input logic [ADDR_W-1:0] awaddr,
  input logic              awvalid,
  input logic              awready,
  input logic [DATA_W-1:0] wdata,
  input logic              wlast,
  input logic              wvalid,
  input logic              wready,
  input logic              bready
);
  a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    ready_o |-> !arvalid && !awvalid && !wvalid && !rready && !bready);

  a_r4_ar_hold: assert property (@(posedge clk) disable iff (!rst_n)
    arvalid && !arready && !cancel_i |=> arvalid && $stable(araddr));

  a_r6_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid_o |=> !rd_valid_o);

  a_r6_valid_idle: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid_o |-> ready_o);

  a_r8_aw_hold: assert property (@(posedge clk) disable iff (!rst_n)
    awvalid && !awready |=> awvalid && $stable(awaddr));

  a_r8_w_hold: assert property (@(posedge clk) disable iff (!rst_n)
    wvalid && !wready |=> wvalid && $stable(wdata) && $stable(wlast));

  a_r9_bready_after: assert property (@(posedge clk) disable iff (!rst_n)
    bready |-> !awvalid && !wvalid);

  a_r10_one_side: assert property (@(posedge clk) disable iff (!rst_n)
    !(arvalid && (awvalid || wvalid)));
endmodule

bind axi_burst_bridge axi_burst_bridge_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ready_o(ready_o), .rd_valid_o(rd_valid_o),
  .cancel_i(cancel_i), .araddr(araddr), .arvalid(arvalid), .arready(arready),
  .rready(rready), .awaddr(awaddr), .awvalid(awvalid), .awready(awready),
  .wdata(wdata), .wlast(wlast), .wvalid(wvalid), .wready(wready), .bready(bready)
);

// File: tb/axi_burst_bridge_test.sv
`timescale 1ns/1ps
module axi_burst_bridge_test;
  localparam int AW = 32, DW = 32, BW = 128, IW = 4;
  localparam int BEATS = BW / DW;

  logic clk = 0, rst_n = 0;
  logic req_rd_i = 0, req_wr_i = 0, cancel_i = 0;
  logic [AW-1:0] addr_i = '0;
  logic [BW-1:0] wbuf_i = '0;
  logic ready_o, rd_valid_o;
  logic [BW-1:0] rbuf_o;
  logic [IW-1:0] arid, awid;
  logic [AW-1:0] araddr, awaddr;
  logic [7:0] arlen, awlen;
  logic [2:0] arsize, awsize;
  logic [1:0] arburst, awburst;
  logic arvalid, awvalid, wvalid, wlast, rready, bready;
  logic arready = 0, awready = 0, wready = 0, rvalid = 0, rlast = 0, bvalid = 0;
  logic [DW-1:0] rdata = '0, wdata;
  logic [DW/8-1:0] wstrb;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  axi_burst_bridge #(.ADDR_W(AW), .DATA_W(DW), .BUF_W(BW), .ID_W(IW)) uut (
    .clk(clk), .rst_n(rst_n), .req_rd_i(req_rd_i), .req_wr_i(req_wr_i),
    .cancel_i(cancel_i), .addr_i(addr_i), .wbuf_i(wbuf_i), .ready_o(ready_o),
    .rd_valid_o(rd_valid_o), .rbuf_o(rbuf_o), .arid(arid), .araddr(araddr),
    .arlen(arlen), .arsize(arsize), .arburst(arburst), .arvalid(arvalid),
    .arready(arready), .rdata(rdata), .rlast(rlast), .rvalid(rvalid),
    .rready(rready), .awid(awid), .awaddr(awaddr), .awlen(awlen),
    .awsize(awsize), .awburst(awburst), .awvalid(awvalid), .awready(awready),
    .wdata(wdata), .wstrb(wstrb), .wlast(wlast), .wvalid(wvalid),
    .wready(wready), .bvalid(bvalid), .bready(bready)
  );

  // {is_write, address, delay_a, delay_b}
  // read : delay_a = arready delay, delay_b[0] = gap between beats
  // write: delay_a = awready delay, delay_b = wready delay
  localparam logic [40:0] VEC [0:5] = '{
    {1'b0, 32'h0000_1000, 4'd0, 4'd0},
    {1'b0, 32'h0000_2040, 4'd3, 4'd1},
    {1'b1, 32'h0000_3000, 4'd0, 4'd0},
    {1'b1, 32'h0000_4080, 4'd5, 4'd0},
    {1'b1, 32'h0000_50C0, 4'd0, 4'd4},
    {1'b0, 32'hFFFF_FFF0, 4'd1, 4'd0}
  };

  task automatic check(input string tag, input logic [BW-1:0] act, input logic [BW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] rd_beat(input logic [AW-1:0] a, input int k);
    return (a + DW'(k) * 32'h1111_1111) ^ 32'h5A5A_0000;
  endfunction

  function automatic logic [BW-1:0] wr_buf(input logic [AW-1:0] a);
    logic [BW-1:0] b;
    for (int k = 0; k < BEATS; k++) b[k*DW +: DW] = ~a + DW'(k) * 32'h0101_0101;
    return b;
  endfunction

  function automatic logic [BW-1:0] rd_buf(input logic [AW-1:0] a);
    logic [BW-1:0] b;
    for (int k = 0; k < BEATS; k++) b[k*DW +: DW] = rd_beat(a, k);
    return b;
  endfunction

  task automatic ar_phase(input logic [AW-1:0] a, input int ard);
    @(negedge clk) begin req_rd_i = 1; addr_i = a; end
    @(negedge clk) begin req_rd_i = 0; addr_i = '1; end
    check("R3 arvalid", BW'(arvalid), BW'(1));
    check("R3 araddr", BW'(araddr), BW'(a));
    check("R3 arlen/arsize/arburst/arid", BW'({arlen, arsize, arburst, arid}),
          BW'({8'(BEATS-1), 3'd2, 2'b01, 4'd0}));
    check("R2 ready low when busy", BW'(ready_o), BW'(0));
    repeat (ard) @(negedge clk);
    arready = 1;
    @(negedge clk) arready = 0;
    check("R5 rready", BW'(rready), BW'(1));
  endtask

  task automatic read_beats(input logic [AW-1:0] a, input bit gap);
    for (int k = 0; k < BEATS; k++) begin
      rvalid = 1; rdata = rd_beat(a, k); rlast = (k == BEATS-1);
      @(negedge clk) begin rvalid = 0; rlast = 0; end
      if (gap && k < BEATS-1) @(negedge clk);
    end
    check("R6 rd_valid pulse", BW'(rd_valid_o), BW'(1));
    check("R6 ready after read", BW'(ready_o), BW'(1));
    check("R5 read buffer", rbuf_o, rd_buf(a));
    @(negedge clk);
    check("R6 pulse one cycle", BW'(rd_valid_o), BW'(0));
  endtask

  task automatic do_write(input logic [AW-1:0] a, input int awd, input int wd);
    int beat = 0;
    bit aw_seen = 0;
    logic [BW-1:0] buf_x = wr_buf(a);
    @(negedge clk) begin req_wr_i = 1; addr_i = a; wbuf_i = buf_x; end
    @(negedge clk) begin req_wr_i = 0; addr_i = '0; wbuf_i = ~buf_x; end
    for (int cyc = 0; cyc < 64 && !(aw_seen && beat == BEATS); cyc++) begin
      check("R9 bready waits", BW'(bready), BW'(0));
      awready = awvalid && (cyc >= awd);
      wready  = wvalid && (cyc >= wd);
      if (awready) begin
        check("R7 awaddr", BW'(awaddr), BW'(a));
        check("R7 awlen/awsize/awburst/awid", BW'({awlen, awsize, awburst, awid}),
              BW'({8'(BEATS-1), 3'd2, 2'b01, 4'd0}));
        aw_seen = 1;
      end
      if (wready) begin
        check("R7 wdata", BW'(wdata), BW'(buf_x[beat*DW +: DW]));
        check("R7 wlast/wstrb", BW'({wlast, wstrb}), BW'({beat == BEATS-1, 4'hF}));
        beat++;
      end
      @(negedge clk) begin awready = 0; wready = 0; end
    end
    check("R8 both phases done", BW'({aw_seen, 8'(beat)}), BW'({1'b1, 8'(BEATS)}));
    check("R9 bready after both", BW'(bready), BW'(1));
    check("R9 still busy", BW'(ready_o), BW'(0));
    bvalid = 1;
    @(negedge clk) bvalid = 0;
    check("R9 idle after response", BW'({ready_o, awvalid, wvalid}), BW'(3'b100));
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1 reset outputs", BW'({ready_o, rd_valid_o, arvalid, awvalid, wvalid, rready, bready}),
          BW'(7'b1000000));
    check("R1 reset rbuf", rbuf_o, '0);

    foreach (VEC[i]) begin
      if (VEC[i][40]) do_write(VEC[i][39:8], int'(VEC[i][7:4]), int'(VEC[i][3:0]));
      else begin
        ar_phase(VEC[i][39:8], int'(VEC[i][7:4]));
        read_beats(VEC[i][39:8], VEC[i][0]);
      end
    end

    // R4: cancel alone
    @(negedge clk) begin req_rd_i = 1; addr_i = 32'h7000; end
    @(negedge clk) begin req_rd_i = 0; cancel_i = 1; end
    @(negedge clk) cancel_i = 0;
    check("R4 cancel returns idle", BW'({ready_o, arvalid, rready}), BW'(3'b100));
    check("R4 no valid after cancel", BW'(rd_valid_o), BW'(0));
    check("R4 buffer untouched", rbuf_o, rd_buf(32'hFFFF_FFF0));

    // R4: cancel with arready in the same cycle
    @(negedge clk) begin req_rd_i = 1; addr_i = 32'h7100; end
    @(negedge clk) begin req_rd_i = 0; cancel_i = 1; arready = 1; end
    @(negedge clk) begin cancel_i = 0; arready = 0; end
    check("R4 handshake wins", BW'({rready, ready_o}), BW'(2'b10));
    read_beats(32'h7100, 0);

    // R2: requests while busy are ignored
    ar_phase(32'h7200, 0);
    @(negedge clk) begin req_wr_i = 1; req_rd_i = 1; addr_i = 32'h9999; end
    @(negedge clk) begin req_wr_i = 0; req_rd_i = 0; end
    check("R2 busy request ignored", BW'({awvalid, arvalid, rready}), BW'(3'b001));
    read_beats(32'h7200, 1);
    check("R2 nothing pending", BW'({ready_o, awvalid, arvalid}), BW'(3'b100));

    // R10: simultaneous requests
    @(negedge clk) begin req_rd_i = 1; req_wr_i = 1; addr_i = 32'h8000; wbuf_i = '1; end
    @(negedge clk) begin req_rd_i = 0; req_wr_i = 0; end
    check("R10 read taken", BW'({arvalid, awvalid, wvalid}), BW'(3'b100));
    check("R10 read address", BW'(araddr), BW'(32'h8000));
    arready = 1;
    @(negedge clk) arready = 0;
    read_beats(32'h8000, 0);
    check("R10 write dropped", BW'({ready_o, awvalid, wvalid}), BW'(3'b100));

    finish_run();
  end
endmodule